// File: doc/BRIEF.md
# Single-Channel PWM with Atomic Settings Update

This block produces one pulse-width modulated output from a free-running counter. Software programs it through a small word-addressed register port. It writes a period and a duty count, each measured in input clock cycles, and a control word. The control word turns the channel on, selects continuous operation, and sets the output level for the duty phase and for the inactive phase.

The block holds two copies of its settings. Register writes land in a staged copy. The counter and comparator work only from an active copy. The staged copy moves into the active copy in one step, and only on the clock edge that starts a new period, so the output never shows a partial update.

A lock bit in the control word stops that transfer. Software can set the lock, change the period, the duty and both levels, and then clear the lock. The whole new set then takes effect together at the first period start after the lock is released.

Top module: `pwm_lockshadow`

## Requirements
- R1: After reset, the control word reads 0x18, which means both level fields are high and every other field is zero. Period, duty and counter read 0, and the output is high.
- R2: The register at offset 0x0 returns the live count. While the channel runs with a nonzero active period P, the count steps 0, 1, …, P−1 and then returns to 0.
- R3: Within each period the output holds the duty level while count < duty and the inactive level otherwise. Control bit 3 gives the duty level and bit 4 gives the inactive level, with 1 meaning high.
- R4: When the active duty is equal to or greater than the active period, the output holds the duty level for the whole period.
- R5: When the active period is 0, the count stays at 0 and the output holds the inactive level.
- R6: While control bit 6 (lock) is set, writes to period (offset 0x4), duty (offset 0x8) and the level fields do not change the output. Period and duty read back the last value written.
- R7: After the lock is cleared, the period in progress completes with the old settings. The staged period, duty and both levels then take effect together from the next period start.
- R8: With the lock clear, a period or duty write made in the middle of a period takes effect only at the next period start.
- R9: The counter runs only when bit 0 (enable) is 1 and bits 2:1 (mode) equal 01, which selects continuous operation. Otherwise the count is held at 0 and the output holds the active inactive level.
- R10: Enabling the channel starts a fresh period at count 0 that uses the active settings. Values staged while the channel was off are not used for that period.
- R11: The control word (offset 0xC) stores and returns bits 0–6 and bit 8. Bit 5 selects left alignment and bit 8 disables the low-power mode. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 1 | Modulated output |

## Verification
The output is exercised with several patterns:
- a short normal-polarity period, which shows that the count and the compare line up;
- an inverted long period, which shows that both level fields are honoured;
- a duty that is larger than the period, and a zero period, which cover the two edge cases of the compare.

Each change of settings is written one cycle after a period start. This placement separates three behaviours:
- applying the settings at the period start, which is correct;
- applying them immediately, which cuts the current period short;
- never applying them, which keeps the old pattern running.

A staged duty written while the channel is off makes it possible to tell whether enabling uses the active set or the staged set.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

    localparam int REG_W = 32;

    // Word select taken from byte address bits 3:2
    localparam logic [1:0] SEL_CNT  = 2'd0;
    localparam logic [1:0] SEL_PER  = 2'd1;
    localparam logic [1:0] SEL_DUTY = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    // Control field positions
    localparam int B_EN       = 0;
    localparam int B_MODE     = 1;
    localparam int B_DUTY_HI  = 3;
    localparam int B_IDLE_HI  = 4;
    localparam int B_LEFT     = 5;
    localparam int B_LOCK     = 6;
    localparam int B_LP_OFF   = 8;

    typedef enum logic [1:0] {
        MODE_STOP  = 2'b00,
        MODE_CONT  = 2'b01,
        MODE_RSV_A = 2'b10,
        MODE_RSV_B = 2'b11
    } pwm_mode_e;

    typedef struct packed {
        logic      lp_off;
        logic      lock;
        logic      left;
        logic      idle_hi;
        logic      duty_hi;
        pwm_mode_e mode;
        logic      en;
    } ctrl_t;

    typedef struct packed {
        logic [REG_W-1:0] period;
        logic [REG_W-1:0] duty;
        logic             duty_hi;
        logic             idle_hi;
    } pwm_set_t;

    localparam ctrl_t CTRL_RESET = '{lp_off: 1'b0, lock: 1'b0, left: 1'b0,
                                     idle_hi: 1'b1, duty_hi: 1'b1,
                                     mode: MODE_STOP, en: 1'b0};

    localparam pwm_set_t SET_RESET = '{period: '0, duty: '0,
                                       duty_hi: 1'b1, idle_hi: 1'b1};

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_EN]        = c.en;
        w[B_MODE +: 2] = c.mode;
        w[B_DUTY_HI]   = c.duty_hi;
        w[B_IDLE_HI]   = c.idle_hi;
        w[B_LEFT]      = c.left;
        w[B_LOCK]      = c.lock;
        w[B_LP_OFF]    = c.lp_off;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.en      = w[B_EN];
        c.mode    = pwm_mode_e'(w[B_MODE +: 2]);
        c.duty_hi = w[B_DUTY_HI];
        c.idle_hi = w[B_IDLE_HI];
        c.left    = w[B_LEFT];
        c.lock    = w[B_LOCK];
        c.lp_off  = w[B_LP_OFF];
        return c;
    endfunction

endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
    import pwmx_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic [REG_W-1:0]    live_cnt,
    output logic [REG_W-1:0]    rdata,
    output pwm_set_t            staged,
    output logic                lock,
    output logic                run
);
    localparam int SEL_LSB = 2;

    logic             in_range;
    logic [1:0]       sel;
    ctrl_t            ctrl_q;
    logic [REG_W-1:0] per_q;
    logic [REG_W-1:0] duty_q;

    assign sel = addr[SEL_LSB +: 2];

    generate
        if (ADDR_W > SEL_LSB + 2) begin : g_full_decode
            assign in_range = (addr[ADDR_W-1:SEL_LSB+2] == '0) &&
                              (addr[SEL_LSB-1:0] == '0);
        end else begin : g_min_decode
            assign in_range = (addr[SEL_LSB-1:0] == '0);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            per_q  <= '0;
            duty_q <= '0;
        end else if (wr_en && in_range) begin
            case (sel)
                SEL_PER:  per_q  <= wdata;
                SEL_DUTY: duty_q <= wdata;
                SEL_CTRL: ctrl_q <= word_to_ctrl(wdata);
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (in_range) begin
            case (sel)
                SEL_CNT:  rdata = live_cnt;
                SEL_PER:  rdata = per_q;
                SEL_DUTY: rdata = duty_q;
                default:  rdata = ctrl_to_word(ctrl_q);
            endcase
        end
    end

    assign staged = '{period: per_q, duty: duty_q,
                      duty_hi: ctrl_q.duty_hi, idle_hi: ctrl_q.idle_hi};
    assign lock   = ctrl_q.lock;
    assign run    = ctrl_q.en && (ctrl_q.mode == MODE_CONT);

endmodule

// File: rtl/pwmx_core.sv
module pwmx_core
    import pwmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             lock,
    input  pwm_set_t         staged,
    output logic [REG_W-1:0] cnt,
    output pwm_set_t         active,
    output logic             pwm_out
);
    logic last_cycle;
    logic in_duty;

    // Final count of the period; a zero period makes every cycle a boundary
    assign last_cycle = (active.period == '0) ||
                        (cnt >= active.period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= SET_RESET;
        end else begin
            if (!run || last_cycle) cnt <= '0;
            else                    cnt <= cnt + 1'b1;
            if (run && last_cycle && !lock) active <= staged;
        end
    end

    assign in_duty = run && (active.period != '0) && (cnt < active.duty);
    assign pwm_out = in_duty ? active.duty_hi : active.idle_hi;

endmodule

// File: rtl/pwm_lockshadow.sv
module pwm_lockshadow
    import pwmx_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              pwm_out
);
    logic             run;
    logic             lock;
    logic [REG_W-1:0] cnt;
    pwm_set_t         staged;
    pwm_set_t         active;

    pwmx_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .live_cnt (cnt),
        .rdata    (bus_rdata),
        .staged   (staged),
        .lock     (lock),
        .run      (run)
    );

    pwmx_core u_core (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .lock    (lock),
        .staged  (staged),
        .cnt     (cnt),
        .active  (active),
        .pwm_out (pwm_out)
    );

endmodule

// File: rtl/pwmx_checker.sv
module pwmx_checker
    import pwmx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             lock,
    input logic [REG_W-1:0] cnt,
    input pwm_set_t         active,
    input logic             pwm_out
);
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        (run && active.period != '0) |-> (cnt < active.period));

    a_r4_full_duty: assert property (@(posedge clk) disable iff (rst)
        (run && active.period != '0 && active.duty >= active.period)
        |-> (pwm_out == active.duty_hi));

    a_r5_zero_period: assert property (@(posedge clk) disable iff (rst)
        (active.period == '0) |-> (pwm_out == active.idle_hi && cnt == '0));

    a_r6_locked_hold: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(active));

    a_r7_change_at_start: assert property (@(posedge clk) disable iff (rst)
        (active != $past(active)) |-> (cnt == '0));

    a_r9_stopped_idle: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pwm_out == active.idle_hi));

    a_r9_stopped_count: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

bind pwm_lockshadow pwmx_checker u_pwmx_checker (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .lock    (lock),
    .cnt     (cnt),
    .active  (active),
    .pwm_out (pwm_out)
);

// File: tb/test_pwm_lockshadow.sv
module test_pwm_lockshadow;
    localparam int CLK_P = 10;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          pwm_out;

    always #(CLK_P/2) clk = ~clk;

    pwm_lockshadow #(.ADDR_W(AW)) i_pwm_lockshadow (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    typedef struct {
        logic  lvl;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: one expected output level per cycle, sampled mid-cycle
    always @(negedge clk) begin
        exp_t e;
        if (!rst && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk(e.req, {31'd0, pwm_out}, {31'd0, e.lvl});
        end
    end

    task automatic wr(input logic [3:0] off, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = AW'(off);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = '0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] off, input logic [31:0] exp);
        bus_addr = AW'(off);
        #1;
        chk(req, bus_rdata, exp);
        bus_addr = '0;
    endtask

    // Wait until the count reads 0 just after an edge: the first cycle of a period
    task automatic sync_start();
        do begin
            @(posedge clk);
            #1;
        end while (bus_rdata !== 32'd0);
    endtask

    task automatic push_per(input int per, input int duty, input logic dhi,
                            input logic ihi, input string req);
        for (int k = 0; k < per; k++) begin
            exp_t e;
            e.lvl = (k < duty) ? dhi : ihi;
            e.req = req;
            sb_q.push_back(e);
        end
    endtask

    task automatic push_lvl(input logic v, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.lvl = v;
            e.req = req;
            sb_q.push_back(e);
        end
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd_chk("R1", 4'hC, 32'h18);
        rd_chk("R1", 4'h4, 32'h0);
        rd_chk("R1", 4'h8, 32'h0);
        rd_chk("R1", 4'h0, 32'h0);
        chk("R1", {31'd0, pwm_out}, 32'd1);

        // R11: stored control bits only
        wr(4'hC, 32'hFFFF_FF20);
        rd_chk("R11", 4'hC, 32'h120);
        chk("R9", {31'd0, pwm_out}, 32'd1);

        // R3, R2: normal polarity, period 5, duty 2
        wr(4'h4, 32'd5);
        wr(4'h8, 32'd2);
        wr(4'hC, 32'h0B);
        sync_start();
        push_per(5, 2, 1'b1, 1'b0, "R3");
        push_per(5, 2, 1'b1, 1'b0, "R3");
        push_per(5, 2, 1'b1, 1'b0, "R3");
        drain();
        sync_start();
        for (int k = 1; k < 5; k++) begin
            @(posedge clk);
            #1;
            chk("R2", bus_rdata, 32'(k));
        end
        @(posedge clk);
        #1;
        chk("R2", bus_rdata, 32'd0);

        // R6: lock holds the active set while new values are staged
        wr(4'hC, 32'h4B);
        wr(4'h4, 32'd8);
        wr(4'h8, 32'd6);
        wr(4'hC, 32'h53);
        rd_chk("R6", 4'h4, 32'd8);
        rd_chk("R6", 4'h8, 32'd6);
        sync_start();
        push_per(5, 2, 1'b1, 1'b0, "R6");
        push_per(5, 2, 1'b1, 1'b0, "R6");
        drain();

        // R7: unlock one cycle into a period
        sync_start();
        push_per(5, 2, 1'b1, 1'b0, "R7");
        push_per(8, 6, 1'b0, 1'b1, "R7");
        push_per(8, 6, 1'b0, 1'b1, "R7");
        wr(4'hC, 32'h13);
        drain();

        // R8: unlocked duty write mid-period
        sync_start();
        push_per(8, 6, 1'b0, 1'b1, "R8");
        push_per(8, 3, 1'b0, 1'b1, "R8");
        wr(4'h8, 32'd3);
        drain();

        // R4: duty above period
        sync_start();
        push_per(8, 3, 1'b0, 1'b1, "R4");
        push_lvl(1'b0, 16, "R4");
        wr(4'h8, 32'd9);
        drain();

        // R5: zero period
        sync_start();
        push_lvl(1'b0, 8, "R5");
        push_lvl(1'b1, 6, "R5");
        wr(4'h4, 32'd0);
        drain();
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            chk("R5", bus_rdata, 32'd0);
            chk("R5", {31'd0, pwm_out}, 32'd1);
        end

        // R9: unsupported mode, then enable clear
        wr(4'h4, 32'd4);
        wr(4'h8, 32'd1);
        repeat (4) @(negedge clk);
        wr(4'hC, 32'h15);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            chk("R9", bus_rdata, 32'd0);
            chk("R9", {31'd0, pwm_out}, 32'd1);
        end
        wr(4'hC, 32'h12);
        wr(4'h8, 32'd3);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            chk("R9", bus_rdata, 32'd0);
            chk("R9", {31'd0, pwm_out}, 32'd1);
        end

        // R10: enable starts at count 0 with the active duty of 1
        wr(4'hC, 32'h13);
        rd_chk("R10", 4'h0, 32'd0);
        chk("R10", {31'd0, pwm_out}, 32'd0);
        @(negedge clk);
        rd_chk("R10", 4'h0, 32'd1);
        chk("R10", {31'd0, pwm_out}, 32'd1);
        @(negedge clk);
        rd_chk("R10", 4'h0, 32'd2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule